// File: doc/BRIEF.md
# Shared GPIO Port Pin Controller

This block holds the control state for one general-purpose port of `WIDTH` pins. Any pin of the port can be handed over to an on-chip peripheral. Software writes three registers through a small register bus:

- a data latch, which sets the pin value;
- a direction register, which sets the pin as output or input;
- a pull-enable register.

Each pin also has a peripheral takeover request that carries its own output value and output enable. From these inputs the block produces registered pad controls for every pin: drive value, drive enable, pull enable and pull polarity. It also returns read data for the port.

The port read path has a fixed rule. A pin set as output reads back its latch bit. A pin set as input reads back the synchronized pad level. The direction bit chooses the source even while a peripheral owns the pin.

A pull is applied only while a pin is not driving. The upper pin group (bit `KBI_LO` and above) can serve a keyboard-interrupt function. When that mode is on and set for rising-edge/high-level sensitivity, the pull on those pins becomes a pulldown instead of a pullup.

Top module: `gpio_share_port`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, every register reads as zero. On the pads, `pad_oe`, `pad_out` and `pad_pull_en` are all zero and `pad_pull_up` is all ones, so every pin is an undriven input.
- R2: For a pin whose `periph_en` bit is 0, `pad_oe` equals its direction bit and `pad_out` equals its data-latch bit.
- R3: For a pin whose `periph_en` bit is 1, `pad_oe` equals its `periph_oe` bit and `pad_out` equals its `periph_out` bit. The direction and data bits are ignored.
- R4: A read with `bus_addr`=0 returns, for each pin, the latch bit when the direction bit is 1 and the synchronized pad level when it is 0. This holds whatever the value of `periph_en`.
- R5: A read with `bus_addr`=1 returns the direction register. A read with `bus_addr`=2 returns the pull-enable register. A read with `bus_addr`=3 returns zero. A write with `bus_we` high stores `bus_wdata` to the register that `bus_addr` selects (0 data, 1 direction, 2 pull), and a write to 3 is dropped. `bus_rdata` is registered and follows `bus_addr` one cycle later.
- R6: A pad level change that is present before rising edge k is not yet visible in `bus_rdata` after edge k+1. It is visible after edge k+2. The path is two synchronizer flops followed by the read register.
- R7: `pad_pull_en` of a pin equals its pull-enable bit while that pin's effective `pad_oe` is 0, and is 0 while the pin drives. This holds whether the port or a peripheral owns the pin.
- R8: `pad_pull_up` is 0 (pulldown) only for pins at index `KBI_LO` or above, and only while both `kbi_mode` and `kbi_rise` are 1. In every other case it is 1 (pullup).
- R9: A write to the data latch is stored even while a peripheral owns the pin. The stored value appears on `pad_out` once `periph_en` drops.
- R10: The pad controls are registered. A change on the peripheral inputs reaches the pads at the next rising edge and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select for write and read |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Registered read data |
| periph_en | input | WIDTH | Per-pin peripheral takeover |
| periph_oe | input | WIDTH | Peripheral drive enable per pin |
| periph_out | input | WIDTH | Peripheral drive value per pin |
| kbi_mode | input | 1 | Upper pin group used for keyboard interrupt |
| kbi_rise | input | 1 | Keyboard sensitivity is rising-edge/high-level |
| pad_in | input | WIDTH | Asynchronous pad levels |
| pad_out | output | WIDTH | Pad drive value |
| pad_oe | output | WIDTH | Pad drive enable |
| pad_pull_en | output | WIDTH | Pad pull device enable |
| pad_pull_up | output | WIDTH | Pull polarity: 1 pullup, 0 pulldown |

## Verification
The embedded assertions check, on every cycle:

- the reset state of the pads;
- that no pin ever has its pull on while it drives;
- that the lower pins never get a pulldown;
- that the synchronizer stages shift one cycle apart;
- that the registers hold when no write occurs.

Some behaviours need the bench's scenarios to show them. These are the choice between latch and pad in the readback, the handover from port to peripheral and back with a latch value written in between, the exact latency of a pad change, and the full mix of ownership and sensitivity cases.

// File: rtl/gsp_pkg.sv
package gsp_pkg;
  typedef enum logic [1:0] {
    GSP_DATA = 2'd0,
    GSP_DIR  = 2'd1,
    GSP_PULL = 2'd2,
    GSP_RSVD = 2'd3
  } gsp_addr_e;
endpackage

// File: rtl/gsp_regs.sv
module gsp_regs #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [1:0]       addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] data_q,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] pull_q
);
  import gsp_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      dir_q  <= '0;
      pull_q <= '0;
    end else if (we) begin
      case (gsp_addr_e'(addr))
        GSP_DATA: data_q <= wdata;
        GSP_DIR:  dir_q  <= wdata;
        GSP_PULL: pull_q <= wdata;
        default:  ;
      endcase
    end
  end

  // R9: latch changes only through a write
  p_latch_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(data_q) && $stable(dir_q) && $stable(pull_q));
endmodule

// File: rtl/gsp_sync.sv
module gsp_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;

  // R6: second stage trails the first by exactly one cycle
  p_stage_shift_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> stage2_q == $past(stage1_q));
endmodule

// File: rtl/gsp_pad_mux.sv
module gsp_pad_mux #(
  parameter int WIDTH  = 8,
  parameter int KBI_LO = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] data_q,
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] pull_q,
  input  logic [WIDTH-1:0] periph_en,
  input  logic [WIDTH-1:0] periph_oe,
  input  logic [WIDTH-1:0] periph_out,
  input  logic             kbi_mode,
  input  logic             kbi_rise,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_pull_en,
  output logic [WIDTH-1:0] pad_pull_up
);
  logic pulldown_sel;
  assign pulldown_sel = kbi_mode & kbi_rise;

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    logic oe_eff, out_eff, up_eff;
    assign oe_eff  = periph_en[i] ? periph_oe[i]  : dir_q[i];
    assign out_eff = periph_en[i] ? periph_out[i] : data_q[i];
    if (i >= KBI_LO) begin : g_kbi
      assign up_eff = ~pulldown_sel;
    end else begin : g_plain
      assign up_eff = 1'b1;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        pad_oe[i]      <= 1'b0;
        pad_out[i]     <= 1'b0;
        pad_pull_en[i] <= 1'b0;
        pad_pull_up[i] <= 1'b1;
      end else begin
        pad_oe[i]      <= oe_eff;
        pad_out[i]     <= out_eff;
        pad_pull_en[i] <= pull_q[i] & ~oe_eff;
        pad_pull_up[i] <= up_eff;
      end
    end
  end

  // R1: pads come out of reset as undriven inputs with pullup polarity
  p_reset_pads_r1: assert property (@(posedge clk)
    rst |=> pad_oe == '0 && pad_pull_en == '0 && pad_out == '0 && pad_pull_up == '1);
  // R7: a driving pin never has its pull on
  p_no_pull_drive_r7: assert property (@(posedge clk) disable iff (rst)
    (pad_pull_en & pad_oe) == '0);
  // R8: lower pins are always pullup
  p_low_pullup_r8: assert property (@(posedge clk) disable iff (rst)
    &pad_pull_up[KBI_LO-1:0]);
  // R3: a granted peripheral sets the drive enable one cycle later
  p_periph_oe_r3: assert property (@(posedge clk) disable iff (rst)
    periph_en[0] |=> pad_oe[0] == $past(periph_oe[0]));
endmodule

// File: rtl/gpio_share_port.sv
module gpio_share_port #(
  parameter int WIDTH  = 8,
  parameter int KBI_LO = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_we,
  input  logic [1:0]       bus_addr,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  input  logic [WIDTH-1:0] periph_en,
  input  logic [WIDTH-1:0] periph_oe,
  input  logic [WIDTH-1:0] periph_out,
  input  logic             kbi_mode,
  input  logic             kbi_rise,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_pull_en,
  output logic [WIDTH-1:0] pad_pull_up
);
  import gsp_pkg::*;

  logic [WIDTH-1:0] data_q, dir_q, pull_q, pad_sync;
  logic [WIDTH-1:0] port_view;

  gsp_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .data_q(data_q), .dir_q(dir_q), .pull_q(pull_q)
  );

  gsp_sync #(.WIDTH(WIDTH)) u_sync (
    .clk(clk), .rst(rst), .async_in(pad_in), .sync_out(pad_sync)
  );

  gsp_pad_mux #(.WIDTH(WIDTH), .KBI_LO(KBI_LO)) u_mux (
    .clk(clk), .rst(rst), .data_q(data_q), .dir_q(dir_q), .pull_q(pull_q),
    .periph_en(periph_en), .periph_oe(periph_oe), .periph_out(periph_out),
    .kbi_mode(kbi_mode), .kbi_rise(kbi_rise),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pull_en(pad_pull_en),
    .pad_pull_up(pad_pull_up)
  );

  // R4: direction picks latch or pad, peripheral ownership plays no part
  assign port_view = (data_q & dir_q) | (pad_sync & ~dir_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      case (gsp_addr_e'(bus_addr))
        GSP_DATA: bus_rdata <= port_view;
        GSP_DIR:  bus_rdata <= dir_q;
        GSP_PULL: bus_rdata <= pull_q;
        default:  bus_rdata <= '0;
      endcase
    end
  end

  // R5: reserved address always reads zero
  p_rsvd_zero_r5: assert property (@(posedge clk) disable iff (rst)
    bus_addr == 2'd3 |=> bus_rdata == '0);
endmodule

// File: tb/gpio_share_port_tb_top.sv
module gpio_share_port_tb_top;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] bus_rdata;
  logic [W-1:0] periph_en = '0, periph_oe = '0, periph_out = '0, pad_in = '0;
  logic kbi_mode = 1'b0, kbi_rise = 1'b0;
  logic [W-1:0] pad_out, pad_oe, pad_pull_en, pad_pull_up;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  gpio_share_port #(.WIDTH(W), .KBI_LO(4)) dut_i (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .periph_en(periph_en), .periph_oe(periph_oe), .periph_out(periph_out),
    .kbi_mode(kbi_mode), .kbi_rise(kbi_rise), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pull_en(pad_pull_en),
    .pad_pull_up(pad_pull_up)
  );

  typedef struct packed {
    logic [7:0] dir, data, pull, pen, poe, pout;
    logic       km, kr;
    logic [7:0] e_oe, e_out, e_pe, e_pu;
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{8'hFF, 8'hA5, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 8'hFF, 8'hA5, 8'h00, 8'hFF},
    '{8'h00, 8'h3C, 8'hFF, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 8'h3C, 8'hFF, 8'hFF},
    '{8'h0F, 8'hF0, 8'hFF, 8'hF0, 8'h30, 8'hC0, 1'b0, 1'b0, 8'h3F, 8'hC0, 8'hC0, 8'hFF},
    '{8'h00, 8'hF0, 8'hFF, 8'h00, 8'h00, 8'h00, 1'b1, 1'b1, 8'h00, 8'hF0, 8'hFF, 8'h0F},
    '{8'h00, 8'h00, 8'hAA, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 8'h00, 8'h00, 8'hAA, 8'hFF},
    '{8'h81, 8'hFF, 8'hFF, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 8'h81, 8'hFF, 8'h7E, 8'hFF},
    '{8'h00, 8'h00, 8'h0F, 8'hF0, 8'hF0, 8'h55, 1'b1, 1'b1, 8'hF0, 8'h50, 8'h0F, 8'h0F}
  };

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [W-1:0] r;
    repeat (3) @(negedge clk);
    // R1: values during reset
    check("R1 oe", pad_oe, 8'h00);
    check("R1 pull_en", pad_pull_en, 8'h00);
    check("R1 pull_up", pad_pull_up, 8'hFF);
    rst = 1'b0;
    @(negedge clk);
    check("R1 out", pad_out, 8'h00);
    rd(2'd1, r); check("R1 dir", r, 8'h00);

    // table walk: R2 R3 R7 R8
    foreach (VEC[i]) begin
      wr(2'd0, VEC[i].data);
      wr(2'd1, VEC[i].dir);
      wr(2'd2, VEC[i].pull);
      periph_en = VEC[i].pen; periph_oe = VEC[i].poe; periph_out = VEC[i].pout;
      kbi_mode = VEC[i].km; kbi_rise = VEC[i].kr;
      settle();
      check("R2/R3 oe", pad_oe, VEC[i].e_oe);
      check("R2/R3 out", pad_out, VEC[i].e_out);
      check("R7 pull_en", pad_pull_en, VEC[i].e_pe);
      check("R8 pull_up", pad_pull_up, VEC[i].e_pu);
    end
    kbi_mode = 1'b0; kbi_rise = 1'b0;

    // R4: readback mix with peripheral owning every pin
    periph_en = 8'hFF; periph_oe = 8'h00; pad_in = 8'h5A;
    wr(2'd1, 8'hF0);
    wr(2'd0, 8'hC3);
    settle();
    rd(2'd0, r); check("R4 readback", r, 8'hCA);

    // R5: register readback and reserved address
    wr(2'd2, 8'h3C);
    rd(2'd1, r); check("R5 dir", r, 8'hF0);
    rd(2'd2, r); check("R5 pull", r, 8'h3C);
    wr(2'd3, 8'hFF);
    rd(2'd3, r); check("R5 rsvd", r, 8'h00);
    rd(2'd2, r); check("R5 rsvd write dropped", r, 8'h3C);

    // R6: synchronizer latency
    periph_en = 8'h00;
    wr(2'd1, 8'h00);
    pad_in = 8'h00;
    bus_addr = 2'd0;
    settle();
    check("R6 base", bus_rdata, 8'h00);
    @(negedge clk); pad_in = 8'hFF;
    @(negedge clk); check("R6 after k", bus_rdata, 8'h00);
    @(negedge clk); check("R6 after k+1", bus_rdata, 8'h00);
    @(negedge clk); check("R6 after k+2", bus_rdata, 8'hFF);

    // R9: latch write under peripheral ownership, then release
    wr(2'd1, 8'hFF);
    periph_en = 8'hFF; periph_oe = 8'hFF; periph_out = 8'h00;
    wr(2'd0, 8'h96);
    settle();
    check("R9 owned", pad_out, 8'h00);
    periph_en = 8'h00;
    settle();
    check("R9 released", pad_out, 8'h96);

    // R10: registered pad controls
    @(negedge clk);
    periph_en = 8'hFF; periph_out = 8'h33;
    #2 check("R10 before edge", pad_out, 8'h96);
    @(negedge clk);
    check("R10 after edge", pad_out, 8'h33);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule